// File: doc/BRIEF.md
# Envelope Tick Scheduler and Attenuation Smoother

This block paces the envelope generators of a four-operator voice. Each incoming sample strobe advances a three-step sub-sample phase. Every third strobe it emits a one-cycle tick and advances a global envelope counter. For each operator it turns a 7-bit effective rate into a shift amount and a pattern of eight 3-bit increment codes. It then uses the counter to pick the code that applies on this tick and decodes it into a power-of-two increment, which the envelope state machines outside the block add to their attenuation.

The block also smooths each operator's attenuation between ticks. On the edge that starts a tick, it stores the operator's attenuation as the previous value. Across the next three sub-sample phases its output moves from the previous value, to the average of the previous and current values, to the current value. This softens the steps that the slow envelope update rate would otherwise cause.

Top module: `env_tick_sched`

## Requirements
- R1: A strobe seen on `smp_stb` at a rising edge advances the sub-sample phase 0→1→2→0. The strobe that moves the phase from 2 back to 0 makes `env_tick` high for exactly the next clock cycle. With no strobe, the phase, the counter and the tick stay quiet.
- R2: Each tick adds one to `env_count` in the same edge that raises `env_tick`. A count of 4095 wraps to 1, never to 0, so the count is 0 only before the first tick after reset.
- R3: For an operator with shift s and pattern P, the increment code is P[3k+2:3k], where k = (env_count >> s) & 7.
- R4: Code 0 gives an increment of 0. Code c from 1 to 7 gives 2^(c-1), so the values run 1, 2, 4 and on up to 64.
- R5: An effective rate idx below 34 gives an all-zero pattern. For idx 34..79, let r = idx-32. The shift is 11-(r>>2). Entry k of the pattern is bit k of a row mask chosen by r&3 from 0xAA, 0xBA, 0xEE, 0xFE, in that order.
- R6: For idx 80..91 the shift is 0, with r = idx-32 and g = (r>>2)-12. Entry k is g+1 plus bit k of a row mask chosen by r&3 from 0x00, 0x88, 0xAA, 0xEE, in that order. For idx 92 and 93 every entry is 4 with shift 0. For idx 94 and above the pattern is all zero with shift 0, so the increment is 0.
- R7: On the edge where a strobe ends phase 2, each operator's `op_level` is stored as its previous value. Reset sets every previous value to the maximum attenuation (all ones).
- R8: `op_smooth` shows the stored previous value in phase 0, the live `op_level` in phase 2, and (previous + current) >> 1 in phase 1.
- R9: Synchronous active-high `rst` clears the phase, the counter and the tick, whatever state the block was in before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | One-cycle pulse per output sample |
| op_rate | input | 28 | Four 7-bit effective rates, operator 0 in the low bits |
| op_level | input | 40 | Four 10-bit current attenuations from the envelope state machines |
| env_tick | output | 1 | One-cycle pulse after each third strobe |
| env_count | output | 12 | Global envelope counter |
| op_step | output | 28 | Four 7-bit decoded increments for the current count |
| op_smooth | output | 40 | Four 10-bit blended attenuations |

## Verification
The assertions check on every cycle that:
- phase and counter are frozen between strobes;
- ticks follow strobes;
- the counter steps by one or wraps from 4095 to 1;
- each increment is zero or a single power of two, and is zero for rates of 94 and above;
- the previous value matches the level stored at the tick edge;
- the blend stays between the previous and current values.

The exact codes drawn from each rate's pattern, the average in the middle phase, the tick falling on the third strobe, and the wrap after 4095 ticks can only be shown by the bench's scenarios, which compare against values worked out from the rules above.

// File: rtl/env_tick_pkg.sv
package env_tick_pkg;

    localparam int RATE_W  = 7;
    localparam int CODE_W  = 3;
    localparam int N_ENT   = 8;
    localparam int PAT_W   = CODE_W * N_ENT;
    localparam int SHIFT_W = 4;
    localparam int STEP_W  = 7;

    typedef struct packed {
        logic [SHIFT_W-1:0] shift;
        logic [PAT_W-1:0]   pattern;
    } rate_word_t;

    // Row masks: bit k marks entry k of the pattern
    function automatic logic [7:0] slow_mask(input logic [1:0] row);
        case (row)
            2'd0:    return 8'hAA;
            2'd1:    return 8'hBA;
            2'd2:    return 8'hEE;
            default: return 8'hFE;
        endcase
    endfunction

    function automatic logic [7:0] fast_mask(input logic [1:0] row);
        case (row)
            2'd0:    return 8'h00;
            2'd1:    return 8'h88;
            2'd2:    return 8'hAA;
            default: return 8'hEE;
        endcase
    endfunction

    function automatic rate_word_t rate_lookup(input logic [RATE_W-1:0] idx);
        rate_word_t   rw;
        logic [6:0]   r;
        logic [7:0]   m;
        logic [3:0]   grp;
        rw  = '0;
        r   = idx - 7'd32;
        grp = r[5:2] - 4'd12;
        if (idx >= 7'd34 && idx < 7'd80) begin
            rw.shift = 4'd11 - r[5:2];
            m = slow_mask(r[1:0]);
            for (int k = 0; k < N_ENT; k++)
                rw.pattern[k*CODE_W +: CODE_W] = {2'b00, m[k]};
        end else if (idx >= 7'd80 && idx < 7'd92) begin
            m = fast_mask(r[1:0]);
            for (int k = 0; k < N_ENT; k++)
                rw.pattern[k*CODE_W +: CODE_W] = 3'(grp) + 3'd1 + {2'b00, m[k]};
        end else if (idx >= 7'd92 && idx < 7'd94) begin
            for (int k = 0; k < N_ENT; k++)
                rw.pattern[k*CODE_W +: CODE_W] = 3'd4;
        end
        return rw;
    endfunction

    function automatic logic [STEP_W-1:0] step_decode(input logic [CODE_W-1:0] c);
        return (c == '0) ? '0 : (STEP_W'(1) << (c - 3'd1));
    endfunction

endpackage

// File: rtl/env_tick_timer.sv
module env_tick_timer #(
    parameter int TICK_DIV = 3,
    parameter int CNT_WRAP = 4096,
    localparam int PH_W    = $clog2(TICK_DIV),
    localparam int CNT_W   = $clog2(CNT_WRAP)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stb_i,
    output logic [PH_W-1:0]  phase_o,
    output logic             roll_o,
    output logic             tick_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(TICK_DIV - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CNT_WRAP - 1);

    logic [PH_W-1:0]  phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tick_q;

    assign roll_o = stb_i && (phase_q == PH_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            cnt_q   <= '0;
            tick_q  <= 1'b0;
        end else begin
            tick_q <= roll_o;
            if (roll_o) begin
                phase_q <= '0;
                cnt_q   <= (cnt_q == CNT_LAST) ? CNT_W'(1) : cnt_q + 1'b1;
            end else if (stb_i) begin
                phase_q <= phase_q + 1'b1;
            end
        end
    end

    assign phase_o = phase_q;
    assign tick_o  = tick_q;
    assign cnt_o   = cnt_q;

    AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (rst)
        !stb_i |=> ($stable(phase_q) && $stable(cnt_q))); // R1
    AST_TICK_FOLLOWS_STB: assert property (@(posedge clk) disable iff (rst)
        tick_q |-> $past(stb_i)); // R1
    AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        tick_q |-> ((cnt_q == $past(cnt_q) + 1'b1) ||
                    (cnt_q == CNT_W'(1) && $past(cnt_q) == CNT_LAST))); // R2
    AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (rst)
        tick_q |-> (cnt_q != '0)); // R2

endmodule

// File: rtl/env_rate_step.sv
module env_rate_step
    import env_tick_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic [RATE_W-1:0] rate_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [STEP_W-1:0] step_o
);
    rate_word_t        rw;
    logic [CNT_W-1:0]  shifted;
    logic [2:0]        sel;
    logic [CODE_W-1:0] code;

    always_comb begin
        rw      = rate_lookup(rate_i);
        shifted = cnt_i >> rw.shift;
        sel     = shifted[2:0];
        code    = rw.pattern[int'(sel)*CODE_W +: CODE_W];
        step_o  = step_decode(code);
    end

endmodule

// File: rtl/env_level_blend.sv
module env_level_blend #(
    parameter int ATT_W    = 10,
    parameter int TICK_DIV = 3,
    localparam int PH_W    = $clog2(TICK_DIV)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             roll_i,
    input  logic [PH_W-1:0]  phase_i,
    input  logic [ATT_W-1:0] level_i,
    output logic [ATT_W-1:0] smooth_o
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(TICK_DIV - 1);

    logic [ATT_W-1:0] prev_q;
    logic [ATT_W:0]   sum;

    always_ff @(posedge clk) begin
        if (rst)         prev_q <= '1;
        else if (roll_i) prev_q <= level_i;
    end

    always_comb begin
        sum = {1'b0, prev_q} + {1'b0, level_i};
        if (phase_i == '0)          smooth_o = prev_q;
        else if (phase_i == PH_LAST) smooth_o = level_i;
        else                        smooth_o = sum[ATT_W:1];
    end

    AST_PREV_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        roll_i |=> (prev_q == $past(level_i))); // R7
    AST_BLEND_BOUND: assert property (@(posedge clk) disable iff (rst)
        ((smooth_o >= prev_q) && (smooth_o <= level_i)) ||
        ((smooth_o <= prev_q) && (smooth_o >= level_i))); // R8

endmodule

// File: rtl/env_tick_sched.sv
module env_tick_sched
    import env_tick_pkg::*;
#(
    parameter int NUM_OPS  = 4,
    parameter int ATT_W    = 10,
    parameter int TICK_DIV = 3,
    parameter int CNT_WRAP = 4096,
    localparam int CNT_W   = $clog2(CNT_WRAP)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      smp_stb,
    input  logic [NUM_OPS*RATE_W-1:0] op_rate,
    input  logic [NUM_OPS*ATT_W-1:0]  op_level,
    output logic                      env_tick,
    output logic [CNT_W-1:0]          env_count,
    output logic [NUM_OPS*STEP_W-1:0] op_step,
    output logic [NUM_OPS*ATT_W-1:0]  op_smooth
);
    localparam int PH_W = $clog2(TICK_DIV);

    logic [PH_W-1:0] phase;
    logic            roll;

    env_tick_timer #(
        .TICK_DIV (TICK_DIV),
        .CNT_WRAP (CNT_WRAP)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .stb_i   (smp_stb),
        .phase_o (phase),
        .roll_o  (roll),
        .tick_o  (env_tick),
        .cnt_o   (env_count)
    );

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
        env_rate_step #(
            .CNT_W (CNT_W)
        ) u_step (
            .rate_i (op_rate[i*RATE_W +: RATE_W]),
            .cnt_i  (env_count),
            .step_o (op_step[i*STEP_W +: STEP_W])
        );

        env_level_blend #(
            .ATT_W    (ATT_W),
            .TICK_DIV (TICK_DIV)
        ) u_blend (
            .clk      (clk),
            .rst      (rst),
            .roll_i   (roll),
            .phase_i  (phase),
            .level_i  (op_level[i*ATT_W +: ATT_W]),
            .smooth_o (op_smooth[i*ATT_W +: ATT_W])
        );

        AST_STEP_POW2: assert property (@(posedge clk) disable iff (rst)
            $onehot0(op_step[i*STEP_W +: STEP_W])); // R4
        AST_FAST_RATE_ZERO: assert property (@(posedge clk) disable iff (rst)
            (op_rate[i*RATE_W +: RATE_W] >= 7'd94) |->
            (op_step[i*STEP_W +: STEP_W] == '0)); // R6
    end

endmodule

// File: tb/test_env_tick_sched.sv
module test_env_tick_sched;
    localparam int NOPS = 4;
    localparam int NR   = 14;
    localparam logic [6:0] RATES [NR] = '{7'd0, 7'd33, 7'd34, 7'd35, 7'd36, 7'd37,
                                          7'd50, 7'd79, 7'd80, 7'd85, 7'd91, 7'd92,
                                          7'd94, 7'd127};
    localparam int SLOW_M [4] = '{'hAA, 'hBA, 'hEE, 'hFE};
    localparam int FAST_M [4] = '{'h00, 'h88, 'hAA, 'hEE};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_stb = 1'b0;
    logic [27:0] op_rate = '0;
    logic [39:0] op_level = '0;
    logic        env_tick;
    logic [11:0] env_count;
    logic [27:0] op_step;
    logic [39:0] op_smooth;

    int total = 0;
    int bad = 0;
    int exp_cnt = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    env_tick_sched i_env_tick_sched (
        .clk(clk), .rst(rst), .smp_stb(smp_stb), .op_rate(op_rate),
        .op_level(op_level), .env_tick(env_tick), .env_count(env_count),
        .op_step(op_step), .op_smooth(op_smooth)
    );

    function automatic int ref_step(int rate, int cnt);
        int r, sh, sel, code;
        if (rate < 34 || rate >= 94) return 0;
        r = rate - 32;
        if (r < 48) begin
            sh = 11 - r / 4;
            sel = (cnt >> sh) & 7;
            code = (SLOW_M[r % 4] >> sel) & 1;
        end else if (r < 60) begin
            sel = cnt & 7;
            code = (r / 4 - 12) + 1 + ((FAST_M[r % 4] >> sel) & 1);
        end else begin
            code = 4;
        end
        return (code == 0) ? 0 : (1 << (code - 1));
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic strobe();
        smp_stb = 1'b1;
        @(negedge clk);
        smp_stb = 1'b0;
    endtask

    task automatic do_tick();
        strobe(); strobe(); strobe();
        exp_cnt = (exp_cnt == 4095) ? 1 : exp_cnt + 1;
    endtask

    task automatic set_rates(int a, int b, int c, int d);
        op_rate = {7'(d), 7'(c), 7'(b), 7'(a)};
    endtask

    task automatic check_steps(string req);
        for (int i = 0; i < NOPS; i++)
            chk(req, int'(op_step[i*7 +: 7]), ref_step(int'(op_rate[i*7 +: 7]), int'(env_count)));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        exp_cnt = 0;
    endtask

    initial begin
        #(4 * 190000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int av [4] = '{100, 1023, 0, 500};
        int bv [4] = '{301, 0, 1023, 500};
        op_level = {10'd5, 10'd5, 10'd5, 10'd5};
        @(negedge clk);
        do_reset();
        // R9 reset state, R7 previous value at maximum
        chk("R9 tick after reset", int'(env_tick), 0);
        chk("R9 count after reset", int'(env_count), 0);
        for (int i = 0; i < NOPS; i++)
            chk("R7 reset previous", int'(op_smooth[i*10 +: 10]), 1023);

        // R1 tick on third strobe, one-cycle pulse
        strobe(); chk("R1 no tick after strobe 1", int'(env_tick), 0);
        strobe(); chk("R1 no tick after strobe 2", int'(env_tick), 0);
        strobe(); exp_cnt = 1;
        chk("R1 tick after strobe 3", int'(env_tick), 1);
        chk("R2 first count", int'(env_count), 1);
        @(negedge clk);
        chk("R1 tick lasts one cycle", int'(env_tick), 0);
        repeat (10) @(negedge clk);
        chk("R1 count frozen without strobes", int'(env_count), 1);
        chk("R1 no tick without strobes", int'(env_tick), 0);

        // R7 / R8 blending
        for (int i = 0; i < NOPS; i++) op_level[i*10 +: 10] = 10'(av[i]);
        do_tick();
        chk("R2 second count", int'(env_count), exp_cnt);
        for (int i = 0; i < NOPS; i++) op_level[i*10 +: 10] = 10'(bv[i]);
        #0;
        for (int i = 0; i < NOPS; i++)
            chk("R8 phase 0 shows previous", int'(op_smooth[i*10 +: 10]), av[i]);
        strobe();
        for (int i = 0; i < NOPS; i++)
            chk("R8 phase 1 average", int'(op_smooth[i*10 +: 10]), (av[i] + bv[i]) >> 1);
        strobe();
        for (int i = 0; i < NOPS; i++)
            chk("R8 phase 2 shows current", int'(op_smooth[i*10 +: 10]), bv[i]);
        strobe();
        exp_cnt++;
        for (int i = 0; i < NOPS; i++)
            chk("R7 previous captured at tick", int'(op_smooth[i*10 +: 10]), bv[i]);

        // R3..R6 rate table walk
        for (int k = 0; k < NR; k++) begin
            set_rates(RATES[k], RATES[(k + 1) % NR], RATES[(k + 2) % NR], RATES[(k + 3) % NR]);
            for (int t = 0; t < 8; t++) begin
                do_tick();
                chk("R2 count sequence", int'(env_count), exp_cnt);
                check_steps("R3 R4 R5 R6 step from rate");
            end
        end

        // R9 reset from a running state, then R2 wrap
        do_reset();
        chk("R9 count cleared mid-run", int'(env_count), 0);
        set_rates(34, 37, 81, 92);
        for (int t = 0; t < 4095; t++) do_tick();
        chk("R2 reaches 4095", int'(env_count), 4095);
        check_steps("R3 R5 R6 steps at 4095");
        do_tick();
        chk("R2 wraps to 1", int'(env_count), 1);
        check_steps("R3 R4 steps after wrap");
        set_rates(95, 50, 88, 36);
        do_tick();
        chk("R2 continues after wrap", int'(env_count), 2);
        check_steps("R6 R5 steps after wrap");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule